// File: doc/BRIEF.md
# Programmable Receive Pattern Synchronizer

This block locks a local 32-bit pattern generator to a serial payload stream and then flags every received bit that disagrees with the generator. The generator can be set up as a two-tap pseudo-random sequence, as a QRSS sequence (fixed taps, with long zero runs suppressed), or as a repeating word of any length from 1 to 32 bits. Configuration is taken only when the load control rises, so the configuration inputs may change freely at other times.

Acquisition has three phases. In the first, 32 received bits are written straight into the generator register. In the second, the generator runs on its own feedback and the next 32 received bits must all match its output. The third phase is lock. While locked, a sliding record of the last 64 compared bits counts mismatches. When automatic resynchronization is enabled, a sixth mismatch inside that record sends the block back to the first phase. When it is disabled, lock is held until the next load strobe.

Top module: `rx_pattern_sync`

## Requirements
- R1: After reset `in_sync` and `bit_err` are 0 and the block is in the loading phase.
- R2: A rising edge of `cfg_load` captures all configuration inputs and restarts acquisition at the loading phase, with `in_sync` low after that edge. A bit presented in that same cycle is discarded. Configuration changes without such an edge have no effect.
- R3: After a restart, the first 32 valid bits are shifted directly into the generator register (newest bit in bit 1), and the next 32 valid bits are compared against the generator output. If all of them match, `in_sync` is 1 right after the 64th valid bit.
- R4: A single mismatch during the compare phase returns the block to the loading phase, so lock comes 64 valid bits after the failing bit. `bit_err` stays 0 whenever the block is not locked.
- R5: In two-tap mode (`cfg_rep_mode`=0, `cfg_qrss`=0) the feedback is register bit n XOR bit y. Tap k (1..32) is coded as k-1 on the 5-bit tap fields.
- R6: In repeating mode (`cfg_rep_mode`=1, `cfg_qrss`=0) the feedback is register bit n, so any word of length n locks.
- R7: With `cfg_qrss`=1, the feedback is bit 17 XOR bit 20, the tap fields and the mode bit are ignored, and the output is forced to 1 whenever register bits 1..14 are all 0.
- R8: In two-tap and QRSS modes the feedback is forced to 1 when bits 1..31 are all 0, so an all-zero stream never locks. In repeating mode an all-zero stream locks.
- R9: While locked, `bit_err` is 1 in the cycle after each valid bit that differs from the generator output, and 0 after matching bits and after idle cycles.
- R10: With automatic resync on, the valid bit that brings the number of mismatches among the last 64 locked valid bits to 6 drops `in_sync` after its edge. Five such mismatches keep the lock.
- R11: With automatic resync off, the block stays locked whatever the error density, until a load strobe.
- R12: A cycle with `bit_valid` low changes neither the generator nor the acquisition progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Received payload bit |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| cfg_rep_mode | input | 1 | 1 selects the repeating pattern, 0 the two-tap sequence |
| cfg_qrss | input | 1 | 1 selects QRSS, which overrides the mode bit and taps |
| cfg_tap_n | input | 5 | Tap n minus one |
| cfg_tap_y | input | 5 | Tap y minus one |
| cfg_auto_resync | input | 1 | Allows loss of lock on error density |
| cfg_load | input | 1 | Rising edge captures configuration and restarts |
| in_sync | output | 1 | Locked to the incoming pattern |
| bit_err | output | 1 | Pulse: the previous valid bit mismatched while locked |

## Verification
The per-bit error flag and the loss of lock can fall on the same cycle. The bit that completes six mismatches in the window is itself reported as an error while the lock drops at the same edge. The bench places five mismatches inside one 64-bit span, then adds a sixth mismatch one bit after the oldest has slid out, then a seventh on the very next bit. It expects lock to survive the first of these and to drop, with the error flag high, on the second. A load strobe is also presented together with a valid bit, and the bench judges by the lock cycle that this bit was not counted.

// File: rtl/rps_pkg.sv
package rps_pkg;

  localparam int PAT_W      = 32;
  localparam int TAP_W      = $clog2(PAT_W);
  localparam int QRSS_TAP_A = 17;
  localparam int QRSS_TAP_B = 20;
  localparam int QRSS_ZRUN  = 14;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_SYNC   = 2'd2
  } acq_state_e;

  typedef struct packed {
    logic             rep_mode;
    logic             qrss;
    logic [TAP_W-1:0] tap_n;
    logic [TAP_W-1:0] tap_y;
    logic             auto_resync;
  } pat_cfg_t;

  // Feedback bit entering register bit 1, including the lockup escape.
  function automatic logic pat_feedback(input logic [PAT_W-1:0] r,
                                        input pat_cfg_t c);
    logic fb;
    logic escape_on;
    if (c.qrss)
      fb = r[QRSS_TAP_A-1] ^ r[QRSS_TAP_B-1];
    else if (c.rep_mode)
      fb = r[c.tap_n];
    else
      fb = r[c.tap_n] ^ r[c.tap_y];
    escape_on = c.qrss || !c.rep_mode;
    if (escape_on && (r[PAT_W-2:0] == '0))
      fb = 1'b1;
    return fb;
  endfunction

  // Generator output: the feedback, or 1 when QRSS sees a long zero run.
  function automatic logic pat_output(input logic [PAT_W-1:0] r,
                                      input logic fb,
                                      input pat_cfg_t c);
    if (c.qrss && (r[QRSS_ZRUN-1:0] == '0))
      return 1'b1;
    return fb;
  endfunction

endpackage

// File: rtl/rps_pattern_gen.sv
module rps_pattern_gen
  import rps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             take_input,
  input  logic             bit_in,
  input  pat_cfg_t         cfg,
  output logic             gen_fb,
  output logic             gen_out,
  output logic [PAT_W-1:0] gen_reg
);

  logic next_in;

  always_comb begin
    gen_fb  = pat_feedback(gen_reg, cfg);
    gen_out = pat_output(gen_reg, gen_fb, cfg);
    next_in = take_input ? bit_in : gen_fb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gen_reg <= '0;
    else if (shift_en)
      gen_reg <= {gen_reg[PAT_W-2:0], next_in};
  end

  // R7: QRSS zero run forces a one at the output
  a_r7_qrss_force: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.qrss && gen_reg[QRSS_ZRUN-1:0] == '0) |-> gen_out);

  // R8: lockup escape in the sequence modes
  a_r8_lockup_escape: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg.qrss || !cfg.rep_mode) && gen_reg[PAT_W-2:0] == '0) |-> gen_fb);

  // R3: a shift while loading copies the received bit into bit 1
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && take_input) |=> gen_reg[0] == $past(bit_in));

endmodule

// File: rtl/rps_err_window.sv
module rps_err_window #(
  parameter int WIN    = 64,
  parameter int THRESH = 6,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             err_in,
  output logic [CNT_W-1:0] err_count,
  output logic             loss
);

  logic [WIN-1:0]   hist;
  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    cnt_next = err_count + CNT_W'(err_in) - CNT_W'(hist[WIN-1]);
    loss     = shift_en && (cnt_next >= CNT_W'(THRESH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist      <= '0;
      err_count <= '0;
    end else if (shift_en) begin
      hist      <= {hist[WIN-2:0], err_in};
      err_count <= cnt_next;
    end
  end

  // R10: running count always equals the ones held in the history
  a_r10_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    err_count == CNT_W'($countones(hist)));

endmodule

// File: rtl/rps_acq_fsm.sv
module rps_acq_fsm
  import rps_pkg::*;
#(
  parameter int LEN = PAT_W,
  localparam int CNT_W = $clog2(LEN)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       valid,
  input  logic       mismatch,
  input  logic       loss,
  input  logic       auto_resync,
  output acq_state_e state,
  output logic       load_phase,
  output logic       in_sync,
  output logic       bit_err,
  output logic       win_shift,
  output logic       win_clear
);

  logic [CNT_W-1:0] cnt;
  logic             cnt_last;

  always_comb begin
    cnt_last   = (cnt == CNT_W'(LEN - 1));
    load_phase = (state == ST_LOAD);
    in_sync    = (state == ST_SYNC);
    win_shift  = valid && in_sync && !restart;
    win_clear  = restart || !in_sync;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_LOAD;
      cnt     <= '0;
      bit_err <= 1'b0;
    end else if (restart) begin
      state   <= ST_LOAD;
      cnt     <= '0;
      bit_err <= 1'b0;
    end else if (valid) begin
      bit_err <= in_sync && mismatch;
      unique case (state)
        ST_LOAD: begin
          cnt <= cnt + 1'b1;
          if (cnt_last) begin
            state <= ST_VERIFY;
            cnt   <= '0;
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt_last) begin
              state <= ST_SYNC;
              cnt   <= '0;
            end
          end
        end
        ST_SYNC: begin
          if (auto_resync && loss) begin
            state <= ST_LOAD;
            cnt   <= '0;
          end
        end
        default: begin
          state <= ST_LOAD;
          cnt   <= '0;
        end
      endcase
    end else begin
      bit_err <= 1'b0;
    end
  end

  // R4: one mismatch while verifying goes back to loading
  a_r4_verify_miss_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VERIFY && valid && mismatch) |=> state == ST_LOAD);

  // R4 / R9: no error flag unless the previous cycle was locked
  a_r9_err_only_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SYNC) |=> !bit_err);

  // R11: without auto resync only a restart leaves lock
  a_r11_hold_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && !auto_resync && !restart) |=> in_sync);

  // R3: lock is entered only from the verify phase
  a_r3_sync_from_verify: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !(state == ST_VERIFY && valid && !mismatch && cnt_last))
      |=> !in_sync);

endmodule

// File: rtl/rx_pattern_sync.sv
module rx_pattern_sync
  import rps_pkg::*;
#(
  parameter int WIN    = 64,
  parameter int THRESH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic             bit_valid,
  input  logic             cfg_rep_mode,
  input  logic             cfg_qrss,
  input  logic [TAP_W-1:0] cfg_tap_n,
  input  logic [TAP_W-1:0] cfg_tap_y,
  input  logic             cfg_auto_resync,
  input  logic             cfg_load,
  output logic             in_sync,
  output logic             bit_err
);

  localparam int CNT_W = $clog2(WIN + 1);

  pat_cfg_t         act_cfg;
  logic             load_q;
  logic             load_rise;
  logic             gen_fb;
  logic             gen_out;
  logic [PAT_W-1:0] gen_reg;
  logic             mismatch;
  logic             shift_en;
  logic             load_phase;
  logic             win_shift;
  logic             win_clear;
  logic             win_loss;
  logic [CNT_W-1:0] win_count;
  acq_state_e       state;

  always_comb begin
    load_rise = cfg_load && !load_q;
    shift_en  = bit_valid && !load_rise;
    mismatch  = bit_in ^ gen_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= 1'b0;
      act_cfg <= '0;
    end else begin
      load_q <= cfg_load;
      if (load_rise)
        act_cfg <= '{rep_mode:    cfg_rep_mode,
                     qrss:        cfg_qrss,
                     tap_n:       cfg_tap_n,
                     tap_y:       cfg_tap_y,
                     auto_resync: cfg_auto_resync};
    end
  end

  rps_pattern_gen u_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .take_input (load_phase),
    .bit_in     (bit_in),
    .cfg        (act_cfg),
    .gen_fb     (gen_fb),
    .gen_out    (gen_out),
    .gen_reg    (gen_reg)
  );

  rps_acq_fsm #(.LEN(PAT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (load_rise),
    .valid       (bit_valid),
    .mismatch    (mismatch),
    .loss        (win_loss),
    .auto_resync (act_cfg.auto_resync),
    .state       (state),
    .load_phase  (load_phase),
    .in_sync     (in_sync),
    .bit_err     (bit_err),
    .win_shift   (win_shift),
    .win_clear   (win_clear)
  );

  rps_err_window #(.WIN(WIN), .THRESH(THRESH)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (win_clear),
    .shift_en  (win_shift),
    .err_in    (mismatch),
    .err_count (win_count),
    .loss      (win_loss)
  );

  // R2: a load edge always leaves the block unlocked
  a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> !in_sync);

  // R12: idle cycles keep generator and phase
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !load_rise) |=> ($stable(gen_reg) && $stable(state)));

  // R10: reaching the threshold with auto resync drops lock
  a_r10_loss_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && act_cfg.auto_resync && win_loss && !load_rise) |=> !in_sync);

  // R10: locked with auto resync the window never holds the threshold
  a_r10_count_below: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && act_cfg.auto_resync) |-> win_count < CNT_W'(THRESH));

endmodule

// File: tb/rx_pattern_sync_bench.sv
module rx_pattern_sync_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_in;
  logic       bit_valid;
  logic       cfg_rep_mode;
  logic       cfg_qrss;
  logic [4:0] cfg_tap_n;
  logic [4:0] cfg_tap_y;
  logic       cfg_auto_resync;
  logic       cfg_load;
  logic       in_sync;
  logic       bit_err;

  always #2 clk = ~clk;

  rx_pattern_sync u_rx_pattern_sync (
    .clk             (clk),
    .rst_n           (rst_n),
    .bit_in          (bit_in),
    .bit_valid       (bit_valid),
    .cfg_rep_mode    (cfg_rep_mode),
    .cfg_qrss        (cfg_qrss),
    .cfg_tap_n       (cfg_tap_n),
    .cfg_tap_y       (cfg_tap_y),
    .cfg_auto_resync (cfg_auto_resync),
    .cfg_load        (cfg_load),
    .in_sync         (in_sync),
    .bit_err         (bit_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic s_sync;
  logic s_err;

  // bench-side source pattern
  logic [31:0] src;
  int          src_n, src_y;
  bit          src_rep, src_qrss;
  logic [31:0] rep_pat;
  int          rep_len, rep_idx;
  int          forced_hits;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic next_src(output logic b);
    logic fb;
    if (src_rep) begin
      b = rep_pat[rep_idx];
      rep_idx = (rep_idx + 1) % rep_len;
    end else begin
      if (src_qrss) fb = ((src >> 16) ^ (src >> 19)) & 1;
      else          fb = ((src >> (src_n - 1)) ^ (src >> (src_y - 1))) & 1;
      if ((src << 1) == 32'd0) fb = 1'b1;
      b = fb;
      if (src_qrss && (src % 32'd16384) == 32'd0) begin
        b = 1'b1;
        forced_hits++;
      end
      src = (src << 1) | {31'd0, fb};
    end
  endtask

  task automatic send(input logic b);
    @(negedge clk);
    bit_in    = b;
    bit_valid = 1'b1;
    @(posedge clk);
    #1;
    s_sync = in_sync;
    s_err  = bit_err;
  endtask

  task automatic send_src(input logic flip);
    logic b;
    next_src(b);
    send(b ^ flip);
  endtask

  task automatic idle();
    @(negedge clk);
    bit_valid = 1'b0;
    @(posedge clk);
    #1;
    s_sync = in_sync;
    s_err  = bit_err;
  endtask

  task automatic do_load(input bit rep, input bit q, input int n, input int y,
                         input bit aut, input logic vld, input logic b);
    @(negedge clk);
    cfg_rep_mode    = rep;
    cfg_qrss        = q;
    cfg_tap_n       = 5'(n - 1);
    cfg_tap_y       = 5'(y - 1);
    cfg_auto_resync = aut;
    cfg_load        = 1'b1;
    bit_valid       = vld;
    bit_in          = b;
    @(posedge clk);
    #1;
    s_sync = in_sync;
    src_rep  = rep;
    src_qrss = q;
    src_n    = n;
    src_y    = y;
    @(negedge clk);
    cfg_load  = 1'b0;
    bit_valid = 1'b0;
  endtask

  // R3: 63 valid bits leave it unlocked, the 64th locks
  task automatic expect_lock(input string req);
    for (int i = 0; i < 63; i++) send_src(1'b0);
    chk(req, "in_sync after 63 bits", s_sync, 0);
    send_src(1'b0);
    chk(req, "in_sync after 64 bits", s_sync, 1);
  endtask

  task automatic run_clean(input int nbits, input string req);
    int errs;
    errs = 0;
    for (int i = 0; i < nbits; i++) begin
      send_src(1'b0);
      if (s_err || !s_sync) errs++;
    end
    chk(req, "errors or loss on clean stream", errs, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int pn[8];
    int py[8];
    int errs;
    int syncs;
    int pulses;
    pn = '{7, 9, 11, 15, 20, 23, 29, 28};
    py = '{6, 5, 9, 14, 3, 18, 27, 31};

    rst_n = 1'b0; bit_in = 1'b0; bit_valid = 1'b0;
    cfg_rep_mode = 1'b0; cfg_qrss = 1'b0; cfg_tap_n = '0; cfg_tap_y = '0;
    cfg_auto_resync = 1'b0; cfg_load = 1'b0;
    src = 32'd1; src_n = 1; src_y = 1; src_rep = 0; src_qrss = 0;
    rep_pat = '0; rep_len = 1; rep_idx = 0; forced_hits = 0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "in_sync in reset", in_sync, 0);
    chk("R1", "bit_err in reset", bit_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "in_sync after reset", in_sync, 0);

    // R6 / R12: every repeating length, with idle cycles mixed in
    for (int n = 1; n <= 32; n++) begin
      do_load(1'b1, 1'b0, n, 1, 1'b1, 1'b0, 1'b0);
      rep_pat = 32'hB4E1_6C3A ^ (32'(n) * 32'h9E37_79B9);
      rep_len = n;
      rep_idx = 0;
      for (int i = 0; i < 63; i++) begin
        if (i % 7 == 3) begin
          idle();
          chk("R12", "bit_err on idle", s_err, 0);
        end
        send_src(1'b0);
      end
      chk("R6", "unlocked after 63 valid bits", s_sync, 0);
      send_src(1'b0);
      chk("R6", "locked after 64 valid bits", s_sync, 1);
      run_clean(30, "R6");
      send_src(1'b1);
      chk("R9", "bit_err on flipped bit", s_err, 1);
      chk("R9", "lock kept after one error", s_sync, 1);
      send_src(1'b0);
      chk("R9", "bit_err after clean bit", s_err, 0);
    end

    // R5: several two-tap sequences
    for (int k = 0; k < 8; k++) begin
      src = 32'h5A5A_1234 + 32'(k);
      do_load(1'b0, 1'b0, pn[k], py[k], 1'b1, 1'b0, 1'b0);
      expect_lock("R5");
      run_clean(200, "R5");
    end

    // R2: inputs change without a load edge, old pattern continues
    cfg_rep_mode = 1'b1; cfg_tap_n = 5'd2; cfg_qrss = 1'b1; cfg_auto_resync = 1'b0;
    run_clean(100, "R2");

    // R2: load edge with a valid bit present; that bit is not counted
    do_load(1'b1, 1'b0, 1, 1, 1'b1, 1'b1, 1'b1);
    chk("R2", "unlocked after load edge", s_sync, 0);
    rep_pat = 32'hFFFF_FFFF; rep_len = 1; rep_idx = 0;
    expect_lock("R2");

    // R4: mismatch at the 8th verify bit
    src = 32'h0BAD_F00D;
    do_load(1'b0, 1'b0, 9, 5, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 39; i++) send_src(1'b0);
    send_src(1'b1);
    chk("R4", "bit_err during verify", s_err, 0);
    chk("R4", "unlocked after verify miss", s_sync, 0);
    expect_lock("R4");

    // R10: window boundary
    src = 32'h1357_9BDF;
    do_load(1'b0, 1'b0, 15, 14, 1'b1, 1'b0, 1'b0);
    expect_lock("R10");
    run_clean(70, "R10");
    pulses = 0;
    for (int k = 0; k < 64; k++) begin
      send_src((k % 10 == 0) && (k <= 40));
      if (s_err) pulses++;
    end
    chk("R10", "error pulses for five flips", pulses, 5);
    chk("R10", "lock with five errors", s_sync, 1);
    send_src(1'b1);
    chk("R10", "lock after oldest slid out", s_sync, 1);
    chk("R9", "bit_err on window bit", s_err, 1);
    send_src(1'b1);
    chk("R10", "lock lost on sixth", s_sync, 0);
    chk("R10", "bit_err with loss", s_err, 1);
    expect_lock("R10");

    // R11: auto resync off
    src = 32'h2468_ACE0;
    do_load(1'b0, 1'b0, 20, 3, 1'b0, 1'b0, 1'b0);
    expect_lock("R11");
    errs = 0;
    for (int i = 0; i < 20; i++) begin
      send_src(1'b1);
      if (s_err) errs++;
    end
    chk("R11", "error pulses for 20 flips", errs, 20);
    chk("R11", "lock held", s_sync, 1);
    src = 32'h7777_1111;
    do_load(1'b0, 1'b0, 23, 18, 1'b1, 1'b0, 1'b0);
    chk("R2", "load drops lock", s_sync, 0);
    expect_lock("R2");

    // R8: all-zero stream
    do_load(1'b0, 1'b0, 7, 6, 1'b1, 1'b0, 1'b0);
    syncs = 0;
    for (int i = 0; i < 300; i++) begin
      send(1'b0);
      if (s_sync) syncs++;
    end
    chk("R8", "two-tap locked on zeros", syncs, 0);
    do_load(1'b1, 1'b0, 5, 1, 1'b1, 1'b0, 1'b0);
    rep_pat = 32'd0; rep_len = 5; rep_idx = 0;
    expect_lock("R8");

    // R7: QRSS with taps set to unrelated values
    src = 32'hACE1_3579;
    do_load(1'b0, 1'b1, 5, 2, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3000 && !s_sync; i++) send_src(1'b0);
    chk("R7", "QRSS lock", s_sync, 1);
    forced_hits = 0;
    errs = 0;
    for (int i = 0; i < 90000 && forced_hits < 2; i++) begin
      send_src(1'b0);
      if (s_err || !s_sync) errs++;
    end
    chk("R7", "errors on QRSS stream", errs, 0);
    chk("R7", "forced ones seen", int'(forced_hits > 0), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule